// File: doc/BRIEF.md
# Double-Buffered Compare Timer Channel

This block is one 16-bit timer channel built around an up-counter that advances on a selectable count tick. The tick comes from a small prescaler, tapped at divide-by-1, divide-by-4 and divide-by-16, or from the rising edge of an external pin. That pin is first synchronized to the system clock. Every tap acts as a clock enable, so all logic runs on the single system clock.

Two compare registers watch the counter. Each one raises its own single-cycle match pulse. Compare register 1 can also reset the counter, which gives a programmable period. Software writes each compare value into a shadow buffer. When double buffering is on and the counter is running, both active compare values are refreshed together at the period match. This lets software change the period and the duty point without a glitch. When the counter is stopped, or buffering is off, a write lands in the active register at once. A one-cycle interrupt pulse marks a natural wrap of the counter from all-ones to zero.

Top module: `dbt_channel`

## Requirements
- R1: While `run` is 1, `count` rises by exactly one on each count tick. With `clr_on_match` at 0 it wraps from 0xFFFF to 0x0000.
- R2: `clk_sel` picks the tick as follows:
  - 0 gives a tick every cycle.
  - 1 gives a tick every 4th running cycle.
  - 2 gives a tick every 16th running cycle.
  - 3 gives a tick on a rising edge of `ext_in`, seen two synchronizer stages later.
  - 4 to 7 give no tick.
  The prescaler is held at zero while `run` is 0.
- R3: One cycle after a clock edge with `run` at 0, `count` reads zero.
- R4: With `clr_on_match` at 1, a tick while `count` equals compare 1 makes `count` zero on the next cycle.
- R5: `ovf_irq` is high for exactly one cycle, in the cycle in which `count` has just wrapped from 0xFFFF to zero. A match clear does not raise it.
- R6: `match0` / `match1` are high for one cycle after each tick at which `count` equalled compare 0 / compare 1.
- R7: After a synchronous reset (`rst_n` low), these all read zero: `count`, both compare values, both shadow buffers, the match pulses and `ovf_irq`.
- R8: A write (`wr_en`=1, `wr_sel` 0 = compare 0, 1 = compare 1) made while `run` is 0 or `dbuf_en` is 0 shows on `cmp0_val`/`cmp1_val` in the next cycle.
- R9: A write made while running with `dbuf_en`=1 changes only the shadow buffer. The active value on `cmp0_val`/`cmp1_val` holds.
- R10: While running with `dbuf_en`=1, a tick at which `count` equals compare 1 copies both shadow buffers into both active compare registers. The copy is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | 1 = count, 0 = stop and force zero |
| clr_on_match | input | 1 | Clear counter on compare-1 match |
| dbuf_en | input | 1 | Enable shadow-buffered compare updates |
| clk_sel | input | 3 | Tick source select (see R2) |
| ext_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write target: 0 = compare 0, 1 = compare 1 |
| wr_data | input | 16 | Compare write value |
| count | output | 16 | Current counter value |
| cmp0_val | output | 16 | Active compare 0 value |
| cmp1_val | output | 16 | Active compare 1 value |
| match0 | output | 1 | Compare 0 match pulse |
| match1 | output | 1 | Compare 1 match pulse |
| ovf_irq | output | 1 | Counter wrap interrupt pulse |

## Verification
A stuck or mis-phased prescaler shows up on `count` first. It changes the spacing of increments within 16 cycles of a start. A bad shadow or active register shows up one cycle after the write or the period match, on `cmp0_val`/`cmp1_val`. It also shifts the cycle of the next `match0`/`match1` pulse. A wrong wrap or clear path shows up on `ovf_irq` and `count` at the tick following 0xFFFF or the compare-1 value.

// File: rtl/dbt_pkg.sv
// Package: shared widths and tick-source codes for the compare timer channel.
// Assumes: codes 4..7 of the tick select are reserved and give no tick.
package dbt_pkg;
    localparam int CNT_W = 16;
    localparam int PSC_W = 4;

    typedef enum logic [2:0] {
        SEL_DIV1  = 3'd0,
        SEL_DIV4  = 3'd1,
        SEL_DIV16 = 3'd2,
        SEL_EXT   = 3'd3
    } tick_sel_e;
endpackage

// File: rtl/dbt_tick_gen.sv
// Module: tick generator. It holds the prescaler counter, the external input
// synchronizer and the source mux. It produces a one-cycle clock enable.
// Assumes: ext_in is asynchronous. The prescaler restarts from zero on every start.
module dbt_tick_gen
    import dbt_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] clk_sel,
    input  logic       ext_in,
    output logic       tick
);
    localparam int Q_BITS = 2;

    logic [PW-1:0] psc;
    logic          sync1, sync2, sync3;
    logic          ext_edge;
    logic          tap_q, tap_full;

    // Prescaler: free-running while run is 1, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) psc <= '0;
        else                psc <= psc + 1'b1;
    end

    // External input: two-stage synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= ext_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign ext_edge = sync2 & ~sync3;
    assign tap_q    = &psc[Q_BITS-1:0];
    assign tap_full = &psc;

    // Source mux: the selected enable, gated by run.
    always_comb begin
        case (clk_sel)
            SEL_DIV1:  tick = run;
            SEL_DIV4:  tick = run & tap_q;
            SEL_DIV16: tick = run & tap_full;
            SEL_EXT:   tick = run & ext_edge;
            default:   tick = 1'b0;
        endcase
    end

    // R2: an external edge never produces two ticks in a row
    p_ext_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clk_sel == SEL_EXT) |=> !(tick && clk_sel == SEL_EXT));
endmodule

// File: rtl/dbt_cmp_bank.sv
// Module: compare register bank. It has two shadow buffers and two active compare registers.
// Assumes: xfer is only raised while running with buffering on. While xfer is
// low, a write goes straight to the active register unless running with buffering on.
module dbt_cmp_bank #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                dbuf_en,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic                xfer,
    output logic [N-1:0][W-1:0] act
);
    logic [N-1:0][W-1:0] shadow;
    logic                direct;

    assign direct = !run || !dbuf_en;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_sel == 1'(i));

        // Shadow buffer: every write targeted at this slot lands here.
        always_ff @(posedge clk) begin
            if (!rst_n)   shadow[i] <= '0;
            else if (hit) shadow[i] <= wr_data;
        end

        // Active register: loaded by a period-match transfer or by a direct write.
        always_ff @(posedge clk) begin
            if (!rst_n)             act[i] <= '0;
            else if (xfer)          act[i] <= shadow[i];
            else if (hit && direct) act[i] <= wr_data;
        end
    end

    // R9: while buffered and running, the active values hold without a transfer
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbuf_en && !xfer) |=> $stable(act));
endmodule

// File: rtl/dbt_channel.sv
// Module: top of the timer channel. It holds the up-counter with clear-on-match
// and the registered match and wrap pulses. The tick generator and compare bank sit below it.
// Assumes: one system clock, synchronous active-low reset, ticks are clock enables.
module dbt_channel
    import dbt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int PW = PSC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr_on_match,
    input  logic         dbuf_en,
    input  logic [2:0]   clk_sel,
    input  logic         ext_in,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp0_val,
    output logic [W-1:0] cmp1_val,
    output logic         match0,
    output logic         match1,
    output logic         ovf_irq
);
    localparam int NCMP = 2;

    logic                   tick;
    logic                   hit0, hit1;
    logic                   period_clr;
    logic                   xfer;
    logic [NCMP-1:0][W-1:0] act;

    dbt_tick_gen #(.PW(PW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_sel (clk_sel),
        .ext_in  (ext_in),
        .tick    (tick)
    );

    dbt_cmp_bank #(.W(W), .N(NCMP)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .dbuf_en (dbuf_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .xfer    (xfer),
        .act     (act)
    );

    assign cmp0_val   = act[0];
    assign cmp1_val   = act[1];
    assign hit0       = (count == cmp0_val);
    assign hit1       = (count == cmp1_val);
    assign period_clr = clr_on_match && hit1;
    assign xfer       = tick && dbuf_en && hit1;

    // Counter: zero while stopped; on a tick, clear at the period or step up.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) count <= '0;
        else if (tick)      count <= period_clr ? '0 : count + 1'b1;
    end

    // Event pulses: one cycle per qualifying tick, aligned with the counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match0  <= 1'b0;
            match1  <= 1'b0;
            ovf_irq <= 1'b0;
        end else begin
            match0  <= tick && hit0;
            match1  <= tick && hit1;
            ovf_irq <= tick && !period_clr && (count == {W{1'b1}});
        end
    end

    // R3: a stop forces the counter to zero
    p_stop_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> count == '0);
    // R1: any non-zero change of the counter is a step of one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && count != $past(count) && count != '0) |-> count == $past(count) + 1'b1);
    // R5: the wrap pulse comes with a zero count reached from all-ones
    p_ovf_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (count == '0 && $past(count) == {W{1'b1}}));
    // R6: a match pulse follows a cycle where counter and compare 0 agreed
    p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match0 |-> $past(count) == $past(cmp0_val));
endmodule

// File: tb/sim_dbt_channel.sv
`timescale 1ns/1ps
module sim_dbt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, clr_on_match = 1'b0, dbuf_en = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic        ext_in = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] count, cmp0_val, cmp1_val;
    logic        match0, match1, ovf_irq;

    always #10 clk = ~clk;

    dbt_channel u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .clr_on_match(clr_on_match),
        .dbuf_en(dbuf_en), .clk_sel(clk_sel), .ext_in(ext_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count(count), .cmp0_val(cmp0_val),
        .cmp1_val(cmp1_val), .match0(match0), .match1(match1), .ovf_irq(ovf_irq)
    );

    // Reference state, computed from the requirements
    logic [15:0] m_cnt, m_c0, m_c1, m_s0, m_s1;
    logic [3:0]  m_psc;
    logic        m_x1, m_x2, m_x3, m_m0, m_m1, m_ovf;
    int          n_chk = 0, n_bad = 0;
    string       tag = "R7";
    bit          done = 1'b0;

    // R2: tick from select code, prescaler phase and synchronized edge
    function automatic logic f_tick(logic r, logic [2:0] sel, logic [3:0] p, logic e);
        case (sel)
            3'd0:    return r;
            3'd1:    return r && (p[1:0] == 2'b11);
            3'd2:    return r && (p == 4'hF);
            3'd3:    return r && e;
            default: return 1'b0;
        endcase
    endfunction

    // R1, R3, R4: next counter value
    function automatic logic [15:0] f_next_cnt(logic r, logic tk, logic clr,
                                               logic [15:0] c, logic [15:0] c1);
        if (!r)                return 16'd0;
        if (!tk)               return c;
        if (clr && (c == c1))  return 16'd0;
        return c + 16'd1;
    endfunction

    task automatic model_step();
        logic tk, h0, h1;
        logic [15:0] o_s0, o_s1;
        if (!rst_n) begin
            m_cnt = 0; m_c0 = 0; m_c1 = 0; m_s0 = 0; m_s1 = 0; m_psc = 0;
            m_x1 = 0; m_x2 = 0; m_x3 = 0; m_m0 = 0; m_m1 = 0; m_ovf = 0;
            return;
        end
        tk = f_tick(run, clk_sel, m_psc, m_x2 & ~m_x3);
        h0 = (m_cnt == m_c0);
        h1 = (m_cnt == m_c1);
        o_s0 = m_s0; o_s1 = m_s1;
        m_m0  = tk && h0;
        m_m1  = tk && h1;
        m_ovf = tk && !(clr_on_match && h1) && (m_cnt == 16'hFFFF);
        m_cnt = f_next_cnt(run, tk, clr_on_match, m_cnt, m_c1);
        if (wr_en && !wr_sel) m_s0 = wr_data;
        if (wr_en &&  wr_sel) m_s1 = wr_data;
        if (tk && dbuf_en && h1) begin
            m_c0 = o_s0; m_c1 = o_s1;                       // R10
        end else if (wr_en && (!run || !dbuf_en)) begin
            if (!wr_sel) m_c0 = wr_data; else m_c1 = wr_data; // R8
        end
        m_psc = run ? m_psc + 4'd1 : 4'd0;
        m_x3 = m_x2; m_x2 = m_x1; m_x1 = ext_in;
    endtask

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("count", count, m_cnt);
        chk("cmp0_val", cmp0_val, m_c0);
        chk("cmp1_val", cmp1_val, m_c1);
        chk("match0", {15'd0, match0}, {15'd0, m_m0});
        chk("match1", {15'd0, match1}, {15'd0, m_m1});
        chk("ovf_irq", {15'd0, ovf_irq}, {15'd0, m_ovf});
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic s, logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        tag = "R7"; steps(3);                      // reset state
        rst_n = 1'b1; step();

        tag = "R8"; dbuf_en = 1'b1;                // stopped: direct write even if buffered
        wr(1'b0, 16'd5); wr(1'b1, 16'd9);

        tag = "R4"; dbuf_en = 1'b0; clr_on_match = 1'b1; run = 1'b1;
        steps(25);                                 // period of 10 with match pulses
        tag = "R6"; steps(12);

        tag = "R9"; dbuf_en = 1'b1;
        wr(1'b0, 16'd3); wr(1'b1, 16'd12);         // shadow only until period match
        steps(2);
        tag = "R10"; steps(30);

        tag = "R8"; dbuf_en = 1'b0; wr(1'b1, 16'd20); steps(10);

        tag = "R3"; run = 1'b0; steps(4);

        tag = "R2";
        for (int s = 1; s < 8; s++) begin
            clk_sel = 3'(s); run = 1'b1;
            for (int k = 0; k < 70; k++) begin
                ext_in = (k % 6) < 3;
                step();
            end
            run = 1'b0; step();
        end

        tag = "R5"; clk_sel = 3'd0; clr_on_match = 1'b0; run = 1'b1;
        steps(65540);                              // one full wrap
        tag = "R1"; steps(20);

        tag = "random";
        for (int k = 0; k < 20000; k++) begin
            if ($urandom % 64 == 0)  run = ~run;
            if ($urandom % 128 == 0) dbuf_en = ~dbuf_en;
            clk_sel      = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
            clr_on_match = ($urandom % 8) != 0;
            ext_in       = ($urandom % 3) == 0;
            wr_en        = ($urandom % 16) == 0;
            wr_sel       = 1'($urandom % 2);
            wr_data      = 16'($urandom % 48);
            step();
        end
        wr_en = 1'b0;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=not finished expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule